// File: doc/BRIEF.md
# Pipelined Burst SRAM with Byte-Lane Writes

This block is a synthesizable synchronous static memory with a pipelined read path and a two-bit burst address sequencer. Address, strobes, selects and write controls are captured on the rising clock edge. A read issued on one edge is placed in the output register on the next edge, and the output drivers are controlled by a drive-enable signal rather than a true tristate bus. The word is split into 9-bit byte lanes, and each lane can be written on its own.

An access starts when a strobe is seen. There are two strobes. The cache strobe always starts an access, and write controls take effect on that same edge. The processor strobe counts only while chip enable is low, and the write controls are not looked at on the edge it starts; they are sampled on the following edge. Once an access is open, the advance input steps the low two address bits in either linear or interleaved order. A sleep input freezes the block while keeping the array contents.

Top module: `psram_ctl`

## Requirements
- R1: The device counts as selected only when `ce_n` is 0, `cs_hi` is 1 and `cs_lo_n` is 0. A start edge (cache strobe low, or processor strobe low with `ce_n` low) without selection closes the access, does no write and loads no read.
- R2: When `gwr_n` is 0 on a write-qualified edge, all four lanes are written from `din`, whatever `bwen_n` and `bsel_n` hold.
- R3: When `gwr_n` is 1 and `bwen_n` is 0, lane g (bits `9g+8:9g` of `din`) is written exactly when `bsel_n[g]` is 0, and any number of lanes may be written on one edge.
- R4: When `gwr_n` and `bwen_n` are both 1, the edge is a read, and the array is left unchanged whatever `bsel_n` holds.
- R5: On an edge where the processor strobe starts an access, the write controls are ignored and a read is done. On the next edge the write controls are sampled. A low processor strobe with `ce_n` high has no effect.
- R6: An address captured as a read on edge k appears on `dout` after edge k+1.
- R7: While an access is open and no strobe is active, `adv_n` = 0 steps a 2-bit burst count and `adv_n` = 1 keeps the current address. The low address bits are base+count modulo 4 when `ilv` = 0, and base XOR count when `ilv` = 1. The sequence wraps to the starting address after four beats.
- R8: An edge that performs any lane write turns `dout_en` off after that edge.
- R9: `dout_en` is high only while `oe_n` is 0, and it follows `oe_n` without waiting for a clock edge.
- R10: After a deselecting start edge, `dout_en` still shows the data of the read that was pending, for one more cycle. It is off from the edge after that on.
- R11: While `sleep` is 1, no state changes, no write happens, `dout` holds and `dout_en` is 0. Array contents survive.
- R12: After reset, no access is open and `dout_en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW | Word address, used on start edges |
| ce_n | input | 1 | Chip enable, active low; also gates the processor strobe |
| cs_hi | input | 1 | Chip select, active high |
| cs_lo_n | input | 1 | Chip select, active low |
| strb_cpu_n | input | 1 | Processor address strobe, active low |
| strb_cache_n | input | 1 | Cache controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gwr_n | input | 1 | Global write, active low |
| bwen_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | LANES | Per-lane byte selects, active low |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| sleep | input | 1 | Freeze and output-disable request |
| ilv | input | 1 | Burst order: 1 interleaved, 0 linear |
| din | input | LANES*LW | Write data |
| dout | output | LANES*LW | Registered read data |
| dout_en | output | 1 | Output drive enable |

## Verification
A read drives the output register on the edge after its address is captured. A write on that same later edge must both update the array and pull the drive-enable low. The bench provokes this by opening an access with the processor strobe as a read, then giving byte-write controls on the very next edge. It judges the result by `dout_en` being low right after that edge and by a later read showing only the selected lanes changed. A second overlap happens when a deselect falls on the same edge as the pending read's output. That case is judged by the drive-enable staying high for exactly one more cycle.

// File: rtl/psram_ctl.sv
module psram_ctl #(
  parameter int AW    = 6,
  parameter int LANES = 4,
  parameter int LW    = 9,
  parameter int BB    = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [AW-1:0]         addr,
  input  logic                  ce_n,
  input  logic                  cs_hi,
  input  logic                  cs_lo_n,
  input  logic                  strb_cpu_n,
  input  logic                  strb_cache_n,
  input  logic                  adv_n,
  input  logic                  gwr_n,
  input  logic                  bwen_n,
  input  logic [LANES-1:0]      bsel_n,
  input  logic                  oe_n,
  input  logic                  sleep,
  input  logic                  ilv,
  input  logic [LANES*LW-1:0]   din,
  output logic [LANES*LW-1:0]   dout,
  output logic                  dout_en
);
  localparam int DEPTH = 1 << AW;

  logic          active, rd_pend, drv;
  logic [AW-1:0] base, rd_addr, eff_addr;
  logic [BB-1:0] cnt, cnt_nx;
  logic [LANES-1:0] wr_sel, lane_we;

  wire sel    = !ce_n && cs_hi && !cs_lo_n;
  wire cpu_go = !strb_cpu_n && !ce_n;
  wire go     = cpu_go || !strb_cache_n;
  wire access = go ? sel : active;
  wire do_wr  = access && !cpu_go && (|wr_sel);
  wire do_rd  = access && !do_wr;

  function automatic logic [AW-1:0] seq_addr(input logic [AW-1:0] b,
                                             input logic [BB-1:0] c,
                                             input logic il);
    logic [BB-1:0] low;
    low = il ? (b[BB-1:0] ^ c) : (b[BB-1:0] + c);
    return {b[AW-1:BB], low};
  endfunction

  always_comb begin
    if (!gwr_n)       wr_sel = '1;
    else if (!bwen_n) wr_sel = ~bsel_n;
    else              wr_sel = '0;
    cnt_nx   = (!go && !adv_n) ? cnt + BB'(1) : cnt;
    eff_addr = go ? addr : seq_addr(base, cnt_nx, ilv);
    lane_we  = do_wr ? wr_sel : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      base    <= '0;
      cnt     <= '0;
      rd_pend <= 1'b0;
      rd_addr <= '0;
      drv     <= 1'b0;
    end else if (!sleep) begin
      if (go) begin
        active <= sel;
        base   <= addr;
        cnt    <= '0;
      end else begin
        cnt    <= cnt_nx;
      end
      rd_pend <= do_rd;
      rd_addr <= eff_addr;
      drv     <= rd_pend && !do_wr;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] arr [DEPTH];
    logic [LW-1:0] q;
    always_ff @(posedge clk) begin
      if (!sleep && lane_we[g]) arr[eff_addr] <= din[g*LW +: LW];
      if (!sleep && rd_pend)    q <= arr[rd_addr];
    end
    assign dout[g*LW +: LW] = q;
  end

  assign dout_en = drv && !oe_n && !sleep;
endmodule

// File: rtl/psram_ctl_chk.sv
module psram_ctl_chk #(
  parameter int AW    = 6,
  parameter int LANES = 4,
  parameter int LW    = 9,
  parameter int BB    = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic [AW-1:0]       addr,
  input logic                ce_n,
  input logic                cs_hi,
  input logic                cs_lo_n,
  input logic                strb_cpu_n,
  input logic                strb_cache_n,
  input logic                adv_n,
  input logic                gwr_n,
  input logic                bwen_n,
  input logic [LANES-1:0]    bsel_n,
  input logic                oe_n,
  input logic                sleep,
  input logic                ilv,
  input logic [LANES*LW-1:0] din,
  input logic [LANES*LW-1:0] dout,
  input logic                dout_en
);
  wire c_sel   = !ce_n && cs_hi && !cs_lo_n;
  wire c_cpu   = !strb_cpu_n && !ce_n;
  wire c_start = c_cpu || !strb_cache_n;
  wire c_wctl  = !gwr_n || (!bwen_n && !(&bsel_n));
  wire c_cache_only = !strb_cache_n && !c_cpu;

  assert_deselect_drive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (c_start && !c_sel && !sleep) ##1 !sleep |=> !dout_en);

  assert_deselect_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (c_start && !c_sel && !sleep) ##1 !sleep |=> $stable(dout));

  assert_write_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && c_cache_only && c_sel && c_wctl) |=> !dout_en);

  assert_sleep_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> $stable(dout));

  assert_read_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep && c_cache_only && c_sel && gwr_n && bwen_n) ##1 (!sleep && gwr_n && bwen_n)
    |=> (sleep || oe_n || dout_en));
endmodule

bind psram_ctl psram_ctl_chk #(.AW(AW), .LANES(LANES), .LW(LW), .BB(BB)) u_chk (.*);

// File: tb/sim_psram_ctl.sv
module sim_psram_ctl;
  localparam int AW = 6, LANES = 4, LW = 9, W = LANES * LW;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] addr = '0;
  logic ce_n = 0, cs_hi = 1, cs_lo_n = 0;
  logic strb_cpu_n = 1, strb_cache_n = 1, adv_n = 1, gwr_n = 1, bwen_n = 1;
  logic [LANES-1:0] bsel_n = '1;
  logic oe_n = 0, sleep = 0, ilv = 0;
  logic [W-1:0] din = '0;
  logic [W-1:0] dout;
  logic dout_en;

  int checks = 0, errors = 0;
  logic [W-1:0] exp_m [1<<AW];

  psram_ctl #(.AW(AW), .LANES(LANES), .LW(LW), .BB(2)) u0 (.*);

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic tick; @(posedge clk); #2; endtask

  task automatic idle;
    strb_cpu_n = 1; strb_cache_n = 1; adv_n = 1; gwr_n = 1; bwen_n = 1; bsel_n = '1;
  endtask

  task automatic deselect;
    idle(); strb_cache_n = 0; ce_n = 1; tick(); ce_n = 0; strb_cache_n = 1;
  endtask

  function automatic logic [W-1:0] merge(input logic [W-1:0] old, input logic [W-1:0] nw, input logic [LANES-1:0] sn);
    logic [W-1:0] r = old;
    for (int g = 0; g < LANES; g++) if (!sn[g]) r[g*LW +: LW] = nw[g*LW +: LW];
    return r;
  endfunction

  task automatic wr_word(input logic [AW-1:0] a, input logic [W-1:0] d);
    idle(); addr = a; din = d; strb_cache_n = 0; gwr_n = 0; tick();
    exp_m[a] = d; deselect();
  endtask

  task automatic rd_check(input logic [AW-1:0] a, input string req);
    idle(); addr = a; strb_cache_n = 0; tick(); idle(); tick();
    chk(dout === exp_m[a] && dout_en, req, dout, exp_m[a]);
    deselect();
  endtask

  task automatic t_reset;
    tick();
    chk(dout_en == 0, "R12 reset drive off", W'(dout_en), 0);
  endtask

  task automatic t_global;
    wr_word(5, 36'h1_2345_6789);
    rd_check(5, "R6 read after global write");
    idle(); addr = 5; din = 36'hA_BCDE_F012; strb_cache_n = 0; gwr_n = 0; bwen_n = 1; bsel_n = '1; tick();
    exp_m[5] = 36'hA_BCDE_F012; deselect();
    rd_check(5, "R2 global write overrides byte controls");
  endtask

  task automatic t_bytes;
    logic [W-1:0] d = 36'h5_5555_5555;
    idle(); addr = 5; din = d; strb_cache_n = 0; bwen_n = 0; bsel_n = 4'b1010; tick();
    exp_m[5] = merge(exp_m[5], d, 4'b1010); deselect();
    rd_check(5, "R3 lanes 0 and 2 written");
    idle(); addr = 5; din = 36'hF_FFFF_FFFF; strb_cache_n = 0; bsel_n = 4'b0000; tick(); deselect();
    rd_check(5, "R4 selects ignored without byte-write enable");
  endtask

  task automatic t_cpu;
    wr_word(20, 36'h0_1111_2222);
    idle(); addr = 20; din = 36'h0_DEAD_BEEF; strb_cpu_n = 0; gwr_n = 0; tick();
    idle(); tick();
    chk(dout === exp_m[20] && dout_en, "R5 write ignored on processor start", dout, exp_m[20]);
    deselect();
    wr_word(21, 36'h3_3333_3333);
    idle(); addr = 21; strb_cpu_n = 0; tick();
    idle(); bwen_n = 0; bsel_n = 4'b1001; din = 36'hC_CCCC_CCCC; tick();
    chk(dout_en == 0, "R8 write edge disables drive", W'(dout_en), 0);
    exp_m[21] = merge(exp_m[21], 36'hC_CCCC_CCCC, 4'b1001); deselect();
    rd_check(21, "R5 deferred byte write");
    idle(); addr = 5; strb_cache_n = 0; tick();
    idle(); strb_cpu_n = 0; ce_n = 1; addr = 30; tick();
    ce_n = 0; idle(); tick();
    chk(dout === exp_m[5] && dout_en, "R5 processor strobe gated by chip enable", dout, exp_m[5]);
    deselect();
  endtask

  task automatic t_burst;
    wr_word(8, 36'h0_0000_0008); wr_word(9, 36'h0_0000_0009);
    wr_word(10, 36'h0_0000_000A); wr_word(11, 36'h0_0000_000B);
    begin
      logic [AW-1:0] lin [4] = '{10, 11, 8, 9};
      logic [AW-1:0] il  [4] = '{9, 8, 11, 10};
      ilv = 0; idle(); addr = 10; strb_cache_n = 0; tick(); idle(); adv_n = 0;
      for (int i = 0; i < 4; i++) begin
        tick(); chk(dout === exp_m[lin[i]], "R7 linear order", dout, exp_m[lin[i]]);
      end
      deselect();
      ilv = 1; idle(); addr = 9; strb_cache_n = 0; tick(); idle(); adv_n = 0;
      for (int i = 0; i < 4; i++) begin
        tick(); chk(dout === exp_m[il[i]], "R7 interleaved order", dout, exp_m[il[i]]);
      end
      tick(); chk(dout === exp_m[9], "R7 wrap to start", dout, exp_m[9]);
      deselect(); ilv = 0;
    end
    idle(); addr = 8; strb_cache_n = 0; tick(); idle(); tick();
    chk(dout === exp_m[8], "R7 hold first", dout, exp_m[8]);
    adv_n = 0; tick();
    chk(dout === exp_m[8], "R7 advance high keeps address", dout, exp_m[8]);
    tick();
    chk(dout === exp_m[9], "R7 advance resumes", dout, exp_m[9]);
    deselect();
  endtask

  task automatic t_select;
    idle(); addr = 9; strb_cache_n = 0; tick(); idle(); tick();
    chk(dout_en == 1, "R10 drive on before deselect", W'(dout_en), 1);
    strb_cache_n = 0; cs_hi = 0; tick();
    chk(dout_en == 1, "R10 drive held one cycle", W'(dout_en), 1);
    cs_hi = 1; idle(); tick();
    chk(dout_en == 0, "R10 drive off after deselect", W'(dout_en), 0);
    idle(); addr = 9; strb_cache_n = 0; tick(); idle(); tick();
    strb_cache_n = 0; cs_lo_n = 1; tick(); cs_lo_n = 0; idle(); tick();
    chk(dout_en == 0, "R1 low-active select off deselects", W'(dout_en), 0);
    idle(); addr = 5; din = 36'h7_7777_7777; strb_cache_n = 0; gwr_n = 0; cs_lo_n = 1; tick();
    cs_lo_n = 0; idle();
    rd_check(5, "R1 no write while not selected");
  endtask

  task automatic t_oe;
    idle(); addr = 9; strb_cache_n = 0; tick(); idle(); tick();
    oe_n = 1; #1;
    chk(dout_en == 0, "R9 output enable high", W'(dout_en), 0);
    oe_n = 0; #1;
    chk(dout_en == 1, "R9 output enable low", W'(dout_en), 1);
    deselect();
  endtask

  task automatic t_sleep;
    sleep = 1; idle(); addr = 8; din = 36'h9_9999_9999; strb_cache_n = 0; gwr_n = 0;
    tick(); tick(); tick();
    chk(dout_en == 0, "R11 sleep disables drive", W'(dout_en), 0);
    idle(); sleep = 0; deselect();
    rd_check(8, "R11 contents retained and sleep write ignored");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    t_reset(); t_global(); t_bytes(); t_cpu(); t_burst(); t_select(); t_oe(); t_sleep();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++; errors++;
    $display("FAIL watchdog R12 actual=%h expected=%h", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule